// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between a byte-wide processor port and a memory that is 16 bits wide. It keeps one aligned two-byte line of instruction stream. When an instruction fetch addresses a byte inside that line, the byte is returned from the buffer and no memory cycle is started. This leaves roughly every second fetch cycle idle on the memory bus, so another master can use it. When a fetch misses, the block reads the whole word, returns the addressed byte in that same cycle and loads the word into the line.

Data reads and writes from the processor go to memory directly and are never cached. Every memory write is watched, whether it comes from the processor port or from another master on the snoop inputs. A write to the buffered word clears the line, so code that modifies itself still fetches fresh bytes. The memory is assumed to answer combinationally within the cycle of its request. `mem_free` tells an external arbiter in which cycles the bus is not needed.

Top module: `ifb_top`

## Requirements
- R1: After reset the line is empty. The first fetch, to any address, starts a memory read (`mem_req`=1, `mem_we`=0).
- R2: A fetch whose address bits [15:1] equal the tag of a valid line raises no `mem_req`. It returns the buffered byte in the same cycle, with `mem_free`=1.
- R3: A fetch miss drives `mem_req`=1, `mem_we`=0, `mem_be`=0 and `mem_addr`=address bits [15:1]. It returns in that cycle the byte chosen by address bit 0 (0 selects `mem_rdata[7:0]`, 1 selects `mem_rdata[15:8]`).
- R4: At the clock edge that ends a fetch miss, the line takes the word and its tag. A later fetch of either byte of that word hits, unless an invalidation comes first.
- R5: A data read starts a memory read and returns the byte chosen by address bit 0. It leaves the line unchanged: a later fetch to the buffered word still hits, and a fetch to the word just read still misses.
- R6: A processor write drives `mem_req`=1 and `mem_we`=1. It sends the write byte on both lanes of `mem_wdata` and sets `mem_be` to the single bit given by address bit 0 (bit 0 for even, bit 1 for odd).
- R7: A processor write, or a snoop write (`snp_we`=1 with `snp_addr` as a word address), to the buffered word invalidates the line. Writes to any other word leave the line intact.
- R8: A snoop write to the word being filled, in the same cycle as the fetch miss, leaves the line invalid.
- R9: `mem_free` is 1 in every cycle in which the block starts no memory cycle, and 0 otherwise.
- R10: When several requests are raised together, a write wins over a data read, and a data read wins over a fetch. Only the winning request is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fch_req | input | 1 | Instruction fetch request |
| dat_req | input | 1 | Data read request |
| wr_req | input | 1 | Data write request |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid in the request cycle |
| mem_free | output | 1 | Bus not used by this block this cycle |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 2 | Write byte lane enables |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, combinational answer |
| snp_we | input | 1 | Write by another master, one bit per snoop port |
| snp_addr | input | 15 | Word address of that write, per snoop port |

## Verification
The bus-side outputs, `mem_free` and `cpu_rdata` all follow the request combinationally in the cycle it is presented. The bench drives inputs on the falling edge and samples these outputs a quarter period later, before the next rising edge. Line updates, whether fills or invalidations, take effect at the rising edge that ends the request cycle. The bench therefore moves its own model of the line one cycle later, and judges the hit or miss of the following fetch against that updated model.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

    // Winning request in the current cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_DREAD = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

endpackage

// File: rtl/ifb_decode.sv
module ifb_decode
    import ifb_pkg::*;
(
    input  logic fch_req,
    input  logic dat_req,
    input  logic wr_req,
    output op_e  op
);

    // R10: write over data read over fetch
    always_comb begin
        if (wr_req)       op = OP_WRITE;
        else if (dat_req) op = OP_DREAD;
        else if (fch_req) op = OP_FETCH;
        else              op = OP_IDLE;
    end

endmodule

// File: rtl/ifb_lanes.sv
module ifb_lanes #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int OFF_W  = $clog2(LANES),
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic [WORD_W-1:0] rd_word,
    input  logic [OFF_W-1:0]  off,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] wr_word
);

    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bytes[i]                = rd_word[i*BYTE_W +: BYTE_W];
        assign wr_word[i*BYTE_W +: BYTE_W]  = wr_byte;
        assign wr_be[i]                     = wr_en && (off == OFF_W'(i));
    end

    assign rd_byte = lane_bytes[off];

endmodule

// File: rtl/ifb_line.sv
module ifb_line #(
    parameter int TAG_W  = 15,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              inval,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] word;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (fill_en) begin
            line_d.valid = 1'b1;
            line_d.tag   = fill_tag;
            line_d.word  = fill_word;
        end
        if (inval) begin
            line_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign valid = line_q.valid;
    assign tag   = line_q.tag;
    assign word  = line_q.word;

    // R4
    fill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !inval |=> valid && tag == $past(fill_tag) && word == $past(fill_word));

    // R7
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !valid);

endmodule

// File: rtl/ifb_top.sv
module ifb_top
    import ifb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BYTE_W  = 8,
    parameter int LANES   = 2,
    parameter int NUM_SNP = 1,
    localparam int OFF_W  = $clog2(LANES),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fch_req,
    input  logic                     dat_req,
    input  logic                     wr_req,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [BYTE_W-1:0]        cpu_wdata,
    output logic [BYTE_W-1:0]        cpu_rdata,
    output logic                     mem_free,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [TAG_W-1:0]         mem_addr,
    output logic [LANES-1:0]         mem_be,
    output logic [WORD_W-1:0]        mem_wdata,
    input  logic [WORD_W-1:0]        mem_rdata,
    input  logic [NUM_SNP-1:0]       snp_we,
    input  logic [NUM_SNP*TAG_W-1:0] snp_addr
);

    op_e               op;
    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [WORD_W-1:0] line_word;
    logic              lookup_hit;
    logic              fetch_hit;
    logic              fill_en;
    logic              own_inval;
    logic [TAG_W-1:0]  watch_tag;
    logic              watch_live;
    logic [NUM_SNP-1:0] snp_match;
    logic              inval;
    logic [WORD_W-1:0] src_word;
    logic [BYTE_W-1:0] sel_byte;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_wdata;

    ifb_decode u_dec (
        .fch_req (fch_req),
        .dat_req (dat_req),
        .wr_req  (wr_req),
        .op      (op)
    );

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    assign lookup_hit = line_valid && (line_tag == req_tag);
    assign fetch_hit  = (op == OP_FETCH) && lookup_hit;
    assign fill_en    = (op == OP_FETCH) && !lookup_hit;
    assign own_inval  = (op == OP_WRITE) && lookup_hit;

    // Snoop compares against the word the line will hold after this edge
    assign watch_tag  = fill_en ? req_tag : line_tag;
    assign watch_live = fill_en || line_valid;

    for (genvar s = 0; s < NUM_SNP; s++) begin : g_snp
        assign snp_match[s] = snp_we[s] && watch_live
                              && (snp_addr[s*TAG_W +: TAG_W] == watch_tag);
    end

    assign inval = own_inval || (|snp_match);

    ifb_line #(
        .TAG_W  (TAG_W),
        .WORD_W (WORD_W)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_tag  (req_tag),
        .fill_word (mem_rdata),
        .inval     (inval),
        .valid     (line_valid),
        .tag       (line_tag),
        .word      (line_word)
    );

    assign src_word = fetch_hit ? line_word : mem_rdata;

    ifb_lanes #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_lanes (
        .rd_word (src_word),
        .off     (req_off),
        .wr_en   (op == OP_WRITE),
        .wr_byte (cpu_wdata),
        .rd_byte (sel_byte),
        .wr_be   (lane_be),
        .wr_word (lane_wdata)
    );

    assign cpu_rdata = sel_byte;
    assign mem_req   = (op != OP_IDLE) && !fetch_hit;
    assign mem_we    = (op == OP_WRITE);
    assign mem_addr  = req_tag;
    assign mem_be    = lane_be;
    assign mem_wdata = lane_wdata;
    assign mem_free  = !mem_req;

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fch_req && !dat_req && !wr_req && line_valid && line_tag == req_tag
        |-> !mem_req && mem_free);

    // R3
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fch_req && !dat_req && !wr_req && !(line_valid && line_tag == req_tag)
        |-> mem_req && !mem_we && mem_be == '0);

    // R5
    dread_line_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_req && !wr_req && snp_we == '0 |=> $stable(line_valid) && $stable(line_tag));

    // R6
    write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> mem_req && mem_we && $onehot(mem_be));

    // R9
    free_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fch_req && !dat_req && !wr_req |-> mem_free && !mem_req);

endmodule

// File: tb/ifb_top_test.sv
module ifb_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fch_req, dat_req, wr_req;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        mem_free, mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [0:0]  snp_we;
    logic [14:0] snp_addr;

    int checks = 0;
    int fails  = 0;

    logic [15:0] bmem [64];
    logic        m_valid;
    logic [14:0] m_tag;
    logic [15:0] m_word;

    always #10 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[5:0]];

    ifb_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fch_req   (fch_req),
        .dat_req   (dat_req),
        .wr_req    (wr_req),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .mem_free  (mem_free),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .snp_we    (snp_we),
        .snp_addr  (snp_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [15:0] a);
        return m_valid && (m_tag == a[15:1]);
    endfunction

    function automatic logic [7:0] pick(input logic [15:0] w, input logic b);
        return b ? w[15:8] : w[7:0];
    endfunction

    // One cycle: drive at falling edge, check, then update model after rising edge
    task automatic step(input logic f, input logic d, input logic w, input logic [15:0] a,
                        input logic [7:0] wd, input logic sw, input logic [14:0] sa,
                        input logic [15:0] snp_data);
        logic hit, fill;
        logic [1:0] kind;
        @(negedge clk);
        fch_req = f; dat_req = d; wr_req = w; cpu_addr = a; cpu_wdata = wd;
        snp_we = sw; snp_addr = sa;
        #5;
        kind = w ? 2'd3 : d ? 2'd2 : f ? 2'd1 : 2'd0;   // R10 priority
        hit  = model_hit(a);
        fill = 1'b0;
        case (kind)
            2'd0: begin
                chk("R9 idle mem_req", mem_req, 0);
                chk("R9 idle mem_free", mem_free, 1);
            end
            2'd1: begin
                if (hit) begin
                    chk("R2 hit mem_req", mem_req, 0);
                    chk("R2 hit mem_free", mem_free, 1);
                    chk("R2 hit rdata", cpu_rdata, pick(m_word, a[0]));
                end else begin
                    fill = 1'b1;
                    chk("R3 miss mem_req", {mem_req, mem_we, mem_be}, 4'b1000);
                    chk("R3 miss mem_addr", mem_addr, a[15:1]);
                    chk("R3 miss rdata", cpu_rdata, pick(bmem[a[6:1]], a[0]));
                    chk("R9 miss mem_free", mem_free, 0);
                end
            end
            2'd2: begin
                chk("R5 dread mem_req", {mem_req, mem_we}, 2'b10);
                chk("R5 dread rdata", cpu_rdata, pick(bmem[a[6:1]], a[0]));
            end
            default: begin
                chk("R6 write ctl", {mem_req, mem_we}, 2'b11);
                chk("R6 write be", mem_be, a[0] ? 2'b10 : 2'b01);
                chk("R6 write data", mem_wdata, {wd, wd});
                chk("R6 write addr", mem_addr, a[15:1]);
            end
        endcase
        @(posedge clk);
        #1;
        if (fill) begin
            m_valid = 1'b1; m_tag = a[15:1]; m_word = bmem[a[6:1]];
        end
        if (kind == 2'd3) begin
            if (hit) m_valid = 1'b0;   // R7
            if (a[0]) bmem[a[6:1]][15:8] = wd;
            else      bmem[a[6:1]][7:0]  = wd;
        end
        if (sw) begin
            if (m_valid && m_tag == sa) m_valid = 1'b0;   // R7, R8
            bmem[sa[5:0]] = snp_data;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 64; i++) bmem[i] = 16'(i * 16'h0123 + 16'h5a0f);
        m_valid = 1'b0; m_tag = '0; m_word = '0;
        fch_req = 0; dat_req = 0; wr_req = 0; cpu_addr = '0; cpu_wdata = '0;
        snp_we = '0; snp_addr = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 reset mem_free", mem_free, 1);

        // R1: first fetch after reset misses even at address 0
        step(1, 0, 0, 16'h0000, 0, 0, 0, 0);
        // R4: odd byte of filled word hits, then even byte
        step(1, 0, 0, 16'h0001, 0, 0, 0, 0);
        step(1, 0, 0, 16'h0000, 0, 0, 0, 0);
        // R5: data read elsewhere keeps line; fetch to read word misses
        step(0, 1, 0, 16'h0023, 0, 0, 0, 0);
        step(1, 0, 0, 16'h0001, 0, 0, 0, 0);
        step(1, 0, 0, 16'h0022, 0, 0, 0, 0);
        // R7: own write to buffered word invalidates
        step(0, 0, 1, 16'h0023, 8'hc3, 0, 0, 0);
        step(1, 0, 0, 16'h0023, 0, 0, 0, 0);
        // R7: snoop to other word keeps line, to same word invalidates
        step(0, 0, 0, 16'h0000, 0, 1, 15'h0005, 16'h1111);
        step(1, 0, 0, 16'h0022, 0, 0, 0, 0);
        step(0, 0, 0, 16'h0000, 0, 1, 15'h0011, 16'h2222);
        step(1, 0, 0, 16'h0022, 0, 0, 0, 0);
        // R8: snoop to the word being filled in the same cycle
        step(1, 0, 0, 16'h0040, 0, 1, 15'h0020, 16'h3333);
        step(1, 0, 0, 16'h0041, 0, 0, 0, 0);
        // R10: all three together act as a write only
        step(1, 1, 1, 16'h0041, 8'h77, 0, 0, 0);
        step(1, 0, 0, 16'h0041, 0, 0, 0, 0);
        step(1, 1, 0, 16'h0004, 0, 0, 0, 0);
        step(1, 0, 0, 16'h0004, 0, 0, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            int r;
            logic f, d, w, sw;
            logic [15:0] a;
            r  = $urandom_range(0, 99);
            f  = (r < 60) || (r >= 95);
            d  = (r >= 60 && r < 75) || (r >= 97);
            w  = (r >= 75 && r < 85) || (r == 99);
            a  = 16'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) a = 16'($urandom_range(0, 127));
            sw = ($urandom_range(0, 9) == 0);
            step(f, d, w, a, 8'($urandom), sw, 15'($urandom_range(0, 8)), 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule